// File: doc/BRIEF.md
# Triangle Sweep Spread-Spectrum Offset Generator

This block makes a digital frequency-offset code that rises and falls as a triangle wave. The code steers a tunable oscillator or a fractional divider so that the clock it drives spreads its energy below the nominal frequency. A code of zero means no offset. Larger codes pull the frequency further down. Because the code is unsigned, the sweep can only go downward from nominal.

One full triangle, up and back down, takes exactly 4096 master clock cycles. A depth select picks between two peak deviations. The wide setting uses the full code range, which stands for 4% below nominal. The narrow setting halves every code, which stands for 2%. Changing the depth does not change the sweep rate or its phase. When the enable input is low, the code is held at zero and the sweep position is cleared. The next enable therefore always starts the sweep from nominal.

Internally, an up/down ramp counter holds its value for one extra cycle at each turning point. A scaling stage turns the counter value into the code and registers it, so the code lags the counter by one cycle.

Top module: `ss_dither_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with the enable low, `offset_o` is 0.
- R2: One cycle after `spread_en_i` is sampled low, `offset_o` is 0, and it stays 0 while the enable stays low. After the enable returns high, the sweep restarts from position 0.
- R3: While the enable and select are held steady, the code repeats with a period of exactly 4096 cycles.
- R4: With `depth_sel_i` = 0 (wide, 4%), the code at enabled edge k (k counted from 0 after enable) is `tri(k)`. Here `tri(p) = p` for `p mod 4096 < 2048`, and `4095 - (p mod 4096)` otherwise. The peak is 2047.
- R5: With `depth_sel_i` = 1 (narrow, 2%), the code is `tri(k)` shifted right by one bit. The peak is 1023.
- R6: The code never exceeds the peak of the depth that was in force at the preceding edge: 2047 for wide, 1023 for narrow.
- R7: While the enable and select are steady, the code changes by at most 1 between consecutive cycles.
- R8: Toggling `depth_sel_i` in the middle of a sweep does not disturb the sweep phase. The next code is the new scaling of the same triangle position.
- R9: The code follows the inputs sampled at the previous rising edge. After the enable rises in wide mode, the first two codes are 0 and then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_en_i | input | 1 | Dither enable; low holds the offset at zero |
| depth_sel_i | input | 1 | Depth select: 1 = 2% (narrow), 0 = 4% (wide) |
| offset_o | output | CNT_W (11) | Unsigned downward frequency offset; 0 is nominal |

## Verification
A wrong ramp position shows up as a wrong code on the very next cycle. A missed or doubled hold at a turning point shifts the phase, which breaks the 4096-cycle repeat within one period. A wrong scaling shows up as a wrong peak, or as a step larger than 1, within half a period of the select changing. A failure to clear on disable leaves a non-zero code one cycle after the enable falls. It can also make the restarted sweep begin away from zero. The bench checks every cycle against a model that works from a phase counter rather than from a direction flag.

// File: rtl/dither_pkg.sv
package dither_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;

  typedef enum logic {
    DEPTH_WIDE   = 1'b0,
    DEPTH_NARROW = 1'b1
  } depth_e;

  // Maps a ramp position to an offset code for the chosen depth.
  function automatic int unsigned depth_scale(int unsigned pos, depth_e depth,
                                              int unsigned shift);
    return (depth == DEPTH_NARROW) ? (pos >> shift) : pos;
  endfunction

endpackage

// File: rtl/dither_tri_ramp.sv
module dither_tri_ramp #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] val_o,
  output logic             dir_up_o,
  output logic             top_o,
  output logic             floor_o
);
  import dither_pkg::*;

  localparam logic [CNT_W-1:0] PEAK = {CNT_W{1'b1}};

  logic [CNT_W-1:0] val_q;
  ramp_dir_e        dir_q;

  // Turning points: the value is held for one cycle while the direction flips.
  assign top_o   = (dir_q == DIR_UP)   && (val_q == PEAK);
  assign floor_o = (dir_q == DIR_DOWN) && (val_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run_i) begin
      val_q <= '0;
      dir_q <= DIR_UP;
    end else if (top_o) begin
      dir_q <= DIR_DOWN;
    end else if (floor_o) begin
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      val_q <= val_q + 1'b1;
    end else begin
      val_q <= val_q - 1'b1;
    end
  end

  assign val_o    = val_q;
  assign dir_up_o = (dir_q == DIR_UP);

endmodule

// File: rtl/dither_depth_scale.sv
module dither_depth_scale #(
  parameter int unsigned CNT_W        = 11,
  parameter int unsigned NARROW_SHIFT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             narrow_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] code_o
);
  import dither_pkg::*;

  logic [CNT_W-1:0] code_d;
  logic [CNT_W-1:0] code_q;
  depth_e           depth;

  assign depth  = narrow_i ? DEPTH_NARROW : DEPTH_WIDE;
  assign code_d = run_i ? CNT_W'(depth_scale(32'(val_i), depth, NARROW_SHIFT)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/ss_dither_gen.sv
module ss_dither_gen #(
  parameter int unsigned CNT_W        = 11,
  parameter int unsigned NARROW_SHIFT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spread_en_i,
  input  logic             depth_sel_i,
  output logic [CNT_W-1:0] offset_o
);

  // Internal events, named for the bound checker.
  logic [CNT_W-1:0] ramp_val;
  logic             ramp_dir_up;
  logic             ramp_top;
  logic             ramp_floor;

  dither_tri_ramp #(
    .CNT_W(CNT_W)
  ) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (spread_en_i),
    .val_o    (ramp_val),
    .dir_up_o (ramp_dir_up),
    .top_o    (ramp_top),
    .floor_o  (ramp_floor)
  );

  dither_depth_scale #(
    .CNT_W       (CNT_W),
    .NARROW_SHIFT(NARROW_SHIFT)
  ) u_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (spread_en_i),
    .narrow_i (depth_sel_i),
    .val_i    (ramp_val),
    .code_o   (offset_o)
  );

endmodule

// File: rtl/ss_dither_chk.sv
module ss_dither_chk #(
  parameter int unsigned CNT_W        = 11,
  parameter int unsigned NARROW_SHIFT = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spread_en_i,
  input logic             depth_sel_i,
  input logic [CNT_W-1:0] offset_o,
  input logic [CNT_W-1:0] ramp_val,
  input logic             ramp_dir_up,
  input logic             ramp_top,
  input logic             ramp_floor
);

  localparam logic [CNT_W-1:0] NARROW_PEAK = {CNT_W{1'b1}} >> NARROW_SHIFT;

  logic             en_d1, en_d2, sel_d1, sel_d2;
  logic [CNT_W-1:0] off_q;
  logic [CNT_W-1:0] step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d1  <= 1'b0;
      en_d2  <= 1'b0;
      sel_d1 <= 1'b0;
      sel_d2 <= 1'b0;
      off_q  <= '0;
    end else begin
      en_d1  <= spread_en_i;
      en_d2  <= en_d1;
      sel_d1 <= depth_sel_i;
      sel_d2 <= sel_d1;
      off_q  <= offset_o;
    end
  end

  assign step = (offset_o >= off_q) ? (offset_o - off_q) : (off_q - offset_o);

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(spread_en_i) |-> offset_o == '0);

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spread_en_i |=> (ramp_val == '0) && ramp_dir_up);

  a_r3_top_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_top && spread_en_i) |=> ($stable(ramp_val) && !ramp_dir_up));

  a_r3_floor_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_floor && spread_en_i) |=> ((ramp_val == '0) && ramp_dir_up));

  a_r5_narrow_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(depth_sel_i) |-> offset_o <= NARROW_PEAK);

  a_r7_small_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_d1 && en_d2 && (sel_d1 == sel_d2)) |-> step <= 1);

endmodule

bind ss_dither_gen ss_dither_chk #(
  .CNT_W       (CNT_W),
  .NARROW_SHIFT(NARROW_SHIFT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .spread_en_i (spread_en_i),
  .depth_sel_i (depth_sel_i),
  .offset_o    (offset_o),
  .ramp_val    (ramp_val),
  .ramp_dir_up (ramp_dir_up),
  .ramp_top    (ramp_top),
  .ramp_floor  (ramp_floor)
);

// File: tb/test_ss_dither_gen.sv
module test_ss_dither_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 4096;
  localparam int HALF       = PER / 2;
  localparam int WIDE_PK    = 2047;
  localparam int NARR_PK    = 1023;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        sel = 1'b0;
  logic [10:0] off;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ss_dither_gen i_ss_dither_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .spread_en_i(en),
    .depth_sel_i(sel),
    .offset_o   (off)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Model: a plain phase counter folded into a triangle.
  function automatic int tri_at(int p);
    int m = p % PER;
    return (m < HALF) ? m : (PER - 1 - m);
  endfunction

  function automatic int scaled(int t, bit narrow);
    return narrow ? t / 2 : t;
  endfunction

  int ph;
  int exp_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0;
      exp_code <= 0;
    end else if (en) begin
      exp_code <= scaled(tri_at(ph), sel);
      ph <= (ph + 1) % PER;
    end else begin
      exp_code <= 0;
      ph <= 0;
    end
  end

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  int hist[PER];
  int max_seen, max_step, prev;

  // Steady sweep: compares each cycle with the model and one period back.
  task automatic sweep(string req, int n);
    max_seen = 0;
    max_step = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, int'(off), exp_code);
      if (i >= PER) chk("R3 period", int'(off), hist[i % PER]);
      hist[i % PER] = int'(off);
      if (i > 0) begin
        if (int'(off) - prev > max_step) max_step = int'(off) - prev;
        if (prev - int'(off) > max_step) max_step = prev - int'(off);
      end
      if (int'(off) > max_seen) max_seen = int'(off);
      prev = int'(off);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    // R1: reset holds the code at zero
    repeat (4) begin
      @(negedge clk);
      chk("R1 in reset", int'(off), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'(off), 0);

    // R9: one-cycle latency after enable, wide mode
    en = 1'b1;
    sel = 1'b0;
    @(negedge clk);
    chk("R9 first code", int'(off), 0);
    @(negedge clk);
    chk("R9 second code", int'(off), 1);

    // R4 wide sweep, two periods
    sweep("R4 wide", 2 * PER);
    chk("R4 wide peak", max_seen, WIDE_PK);
    chk("R7 wide step", max_step, 1);

    // R8: depth change mid-sweep keeps phase
    repeat (700) @(negedge clk);
    sel = 1'b1;
    @(negedge clk);
    chk("R8 select change", int'(off), exp_code);
    chk("R8 select halves", int'(off), scaled(tri_at(ph - 1), 1'b1));

    // R5 narrow sweep
    sweep("R5 narrow", 2 * PER);
    chk("R5 narrow peak", max_seen, NARR_PK);
    chk("R7 narrow step", max_step, 1);

    // R2: disable clears, restart from nominal
    en = 1'b0;
    @(negedge clk);
    chk("R2 disable clears", int'(off), 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R2 held zero", int'(off), 0);
    end
    en = 1'b1;
    sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 restart", int'(off), i);
    end

    // Random toggling of enable and depth
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      chk("R8 random", int'(off), exp_code);
      chk("R6 bound", (int'(off) <= (sel ? NARR_PK : WIDE_PK)) ? 1 : 0, 1);
      if ($urandom_range(0, 599) == 0) sel = ~sel;
      if ($urandom_range(0, 2999) == 0) en = ~en;
      else if (!en && $urandom_range(0, 9) == 0) en = 1'b1;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule